// File: doc/BRIEF.md
# Capture/Reload Timer

A 16-bit up-counter for an 8-bit controller core. It keeps a 16-bit holding register and a control register, all reached through a byte-wide special-register port. The counter advances either on a clock-enable pulse from the core or on falling edges of an external count pin. A falling edge on an external trigger pin does one of two things. In capture mode it copies the counter into the holding register. In reload mode it loads the counter from the holding register.

In reload mode, an overflow reloads the counter from the holding register. This lets the block act as a rate generator for the serial port's receive and transmit clocks. While it serves the serial port, the overflow flag stays quiet and trigger events are blocked. An overflow pulse output and an interrupt request are provided. The interrupt request combines the overflow and trigger flags, and the trigger flag can be masked by a mode bit.

Top module: `cap_reload_timer`

## Requirements
- R1: After reset, every register in the map reads 00h, and irq_o, ovf_o and the serial clock outputs driven by overflow are 0.
- R2: Register map, with sfr_rdata_o showing the register at sfr_addr_i combinationally and a write taking effect at the clock edge where sfr_wr_i is 1:
  - C8h is control. Bit 7 is the overflow flag, bit 6 the trigger flag, bit 5 the receive-clock select, bit 4 the transmit-clock select, bit 3 the trigger enable, bit 2 run, bit 1 the count-pin select and bit 0 capture mode (1) or reload mode (0).
  - C9h is mode. Bit 0 masks the trigger flag from the interrupt, and the other bits read 0.
  - CAh and CBh are the holding register's low and high bytes.
  - CCh and CDh are the counter's low and high bytes.
  - Any other address reads 00h and ignores writes.
- R3: With run=1, the counter advances by one on each cycle with tick_i=1 when bit 1 is 0. When bit 1 is 1 it advances once per falling edge of cnt_pin_i, and ignores tick_i. A pin level counts as changed on the third clock edge after it is applied (two synchronising flops plus one detection stage). With run=0 the counter holds.
- R4: An increment from FFFFh gives a one-cycle ovf_o pulse and sets the overflow flag. In capture mode outside serial-clock use, the counter wraps to 0000h.
- R5: In reload mode, or while either serial-clock select is 1, an overflow loads the counter from the holding register instead of wrapping.
- R6: In capture mode with trigger enable 1, a detected falling edge of trig_pin_i copies the counter's pre-increment value of that cycle into the holding register and sets the trigger flag. The counter still increments or wraps as usual in the same cycle.
- R7: In reload mode with trigger enable 1, a detected falling edge of trig_pin_i loads the counter from the holding register and sets the trigger flag.
- R8: With trigger enable 0, trigger edges change neither the counter, the holding register nor the trigger flag.
- R9: While either serial-clock select bit is 1, the overflow flag is never set, and trigger edges neither capture, reload nor set the trigger flag.
- R10: rx_clk_o equals ovf_o when the receive-clock select is 1, and equals t1_ovf_i otherwise. tx_clk_o does the same using the transmit-clock select.
- R11: Only a control write clears a flag. If the hardware sets a flag in the same cycle as a control write, the flag ends up 1.
- R12: irq_o is 1 when the overflow flag is 1, or when the trigger flag is 1 and mode bit 0 is 0.
- R13: A write to a counter byte in the same cycle as an increment or reload determines that byte's new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable pulse from the core |
| cnt_pin_i | input | 1 | Asynchronous external count pin |
| trig_pin_i | input | 1 | Asynchronous capture/reload trigger pin |
| t1_ovf_i | input | 1 | Overflow pulse of the other timer, default serial clock |
| sfr_addr_i | input | 8 | Register address |
| sfr_wr_i | input | 1 | Register write strobe |
| sfr_wdata_i | input | 8 | Register write data |
| sfr_rdata_o | output | 8 | Register read data |
| ovf_o | output | 1 | Counter overflow pulse |
| rx_clk_o | output | 1 | Receive baud clock pulse |
| tx_clk_o | output | 1 | Transmit baud clock pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
A trigger capture can coincide with an overflow. The bench drops the trigger pin, then writes FFFFh into the counter over the next two cycles, so that a single tick arrives on the exact edge where the synchronised trigger fall is acted upon. It then expects the holding register to contain FFFFh, the counter to be 0000h and both flags to be set. The same technique aligns an overflow with a control write that clears the flags, and a tick with a write to the counter byte. A behavioural model compares every output on every cycle and decides who wins each of these collisions.

// File: rtl/cr_timer_pkg.sv
package cr_timer_pkg;
  localparam logic [7:0] ADDR_CTRL   = 8'hC8;
  localparam logic [7:0] ADDR_MODE   = 8'hC9;
  localparam logic [7:0] ADDR_CAP_LO = 8'hCA;
  localparam logic [7:0] ADDR_CNT_LO = 8'hCC;

  typedef struct packed {
    logic ovf_flag;
    logic trg_flag;
    logic rx_sel;
    logic tx_sel;
    logic trg_en;
    logic run;
    logic pin_cnt;
    logic cap_mode;
  } ctrl_t;
endpackage

// File: rtl/cr_fall_sync.sv
module cr_fall_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic fall_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], pin_i};
  end

  assign fall_o = sh_q[STAGES] & ~sh_q[STAGES-1];

  // one fall per high-to-low transition (R3)
  assert_single_fall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/cr_count_core.sv
module cr_count_core #(
  parameter int W = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          auto_reload_i,
  input  logic          cap_evt_i,
  input  logic          trig_load_i,
  input  logic [W/8-1:0] cnt_we_i,
  input  logic [W/8-1:0] cap_we_i,
  input  logic [7:0]    wdata_i,
  output logic [W-1:0]  cnt_o,
  output logic [W-1:0]  cap_o,
  output logic          ovf_o
);
  localparam int NB = W / 8;

  logic [W-1:0] cnt_q, cnt_d, cap_q, cap_d;

  assign ovf_o = inc_i & (&cnt_q);

  always_comb begin
    cnt_d = cnt_q;
    if (inc_i) cnt_d = ovf_o ? (auto_reload_i ? cap_q : '0) : cnt_q + 1'b1;
    if (trig_load_i) cnt_d = cap_q;
    for (int b = 0; b < NB; b++)
      if (cnt_we_i[b]) cnt_d[8*b +: 8] = wdata_i;
  end

  always_comb begin
    cap_d = cap_q;
    for (int b = 0; b < NB; b++)
      if (cap_we_i[b]) cap_d[8*b +: 8] = wdata_i;
    if (cap_evt_i) cap_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cap_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      cap_q <= cap_d;
    end
  end

  assign cnt_o = cnt_q;
  assign cap_o = cap_q;

  assert_reload_on_ovf_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && auto_reload_i && cnt_we_i == '0) |=> cnt_q == $past(cap_q));

  assert_wrap_on_ovf_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !auto_reload_i && !trig_load_i && cnt_we_i == '0) |=> cnt_q == '0);

  assert_capture_value_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt_i |=> cap_q == $past(cnt_q));
endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer
  import cr_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       cnt_pin_i,
  input  logic       trig_pin_i,
  input  logic       t1_ovf_i,
  input  logic [7:0] sfr_addr_i,
  input  logic       sfr_wr_i,
  input  logic [7:0] sfr_wdata_i,
  output logic [7:0] sfr_rdata_o,
  output logic       ovf_o,
  output logic       rx_clk_o,
  output logic       tx_clk_o,
  output logic       irq_o
);
  localparam int NB = CNT_W / 8;

  ctrl_t ctrl_q, ctrl_d;
  logic  mask_q;
  logic  cnt_fall, trig_fall;
  logic  baud, inc, trig_ok, ovf;
  logic  ctrl_we, mode_we;
  logic [NB-1:0] cnt_we, cap_we;
  logic [CNT_W-1:0] cnt, cap;

  // synchronise both asynchronous pins
  logic [1:0] pins, falls;
  assign pins = {trig_pin_i, cnt_pin_i};
  for (genvar g = 0; g < 2; g++) begin : g_sync
    cr_fall_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i, .rst_ni, .pin_i(pins[g]), .fall_o(falls[g]));
  end
  assign cnt_fall  = falls[0];
  assign trig_fall = falls[1];

  assign ctrl_we = sfr_wr_i && sfr_addr_i == ADDR_CTRL;
  assign mode_we = sfr_wr_i && sfr_addr_i == ADDR_MODE;
  for (genvar b = 0; b < NB; b++) begin : g_we
    assign cnt_we[b] = sfr_wr_i && sfr_addr_i == ADDR_CNT_LO + 8'(b);
    assign cap_we[b] = sfr_wr_i && sfr_addr_i == ADDR_CAP_LO + 8'(b);
  end

  assign baud    = ctrl_q.rx_sel | ctrl_q.tx_sel;
  assign inc     = ctrl_q.run & (ctrl_q.pin_cnt ? cnt_fall : tick_i);
  assign trig_ok = trig_fall & ctrl_q.trg_en & ~baud;

  cr_count_core #(.W(CNT_W)) u_core (
    .clk_i, .rst_ni,
    .inc_i        (inc),
    .auto_reload_i(baud | ~ctrl_q.cap_mode),
    .cap_evt_i    (trig_ok & ctrl_q.cap_mode),
    .trig_load_i  (trig_ok & ~ctrl_q.cap_mode),
    .cnt_we_i     (cnt_we),
    .cap_we_i     (cap_we),
    .wdata_i      (sfr_wdata_i),
    .cnt_o        (cnt),
    .cap_o        (cap),
    .ovf_o        (ovf)
  );

  // hardware flag set wins over a same-cycle software write
  always_comb begin
    ctrl_d = ctrl_we ? ctrl_t'(sfr_wdata_i) : ctrl_q;
    if (ovf && !baud) ctrl_d.ovf_flag = 1'b1;
    if (trig_ok)      ctrl_d.trg_flag = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mask_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      if (mode_we) mask_q <= sfr_wdata_i[0];
    end
  end

  always_comb begin
    sfr_rdata_o = '0;
    if (sfr_addr_i == ADDR_CTRL) sfr_rdata_o = ctrl_q;
    if (sfr_addr_i == ADDR_MODE) sfr_rdata_o = {7'b0, mask_q};
    for (int b = 0; b < NB; b++) begin
      if (sfr_addr_i == ADDR_CNT_LO + 8'(b)) sfr_rdata_o = cnt[8*b +: 8];
      if (sfr_addr_i == ADDR_CAP_LO + 8'(b)) sfr_rdata_o = cap[8*b +: 8];
    end
  end

  assign ovf_o    = ovf;
  assign rx_clk_o = ctrl_q.rx_sel ? ovf : t1_ovf_i;
  assign tx_clk_o = ctrl_q.tx_sel ? ovf : t1_ovf_i;
  assign irq_o    = ctrl_q.ovf_flag | (ctrl_q.trg_flag & ~mask_q);

  assert_no_ovf_flag_baud_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (baud && !ctrl_we) |=> $stable(ctrl_q.ovf_flag));

  assert_trig_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.trg_en && !ctrl_we) |=> $stable(ctrl_q.trg_flag));

  assert_flag_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.ovf_flag && !ctrl_we) |=> ctrl_q.ovf_flag);

  assert_masked_irq_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q && !ctrl_q.ovf_flag) |-> !irq_o);
endmodule

// File: tb/cap_reload_timer_tb.sv
module cap_reload_timer_tb_top;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic tick = 1'b0, cnt_pin = 1'b1, trig_pin = 1'b1, t1_ovf = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic wr = 1'b0;
  logic [7:0] rdata;
  logic ovf, rx_clk, tx_clk, irq;

  always #4 clk = ~clk;

  cap_reload_timer dut_i (
    .clk_i(clk), .rst_ni, .tick_i(tick), .cnt_pin_i(cnt_pin), .trig_pin_i(trig_pin),
    .t1_ovf_i(t1_ovf), .sfr_addr_i(addr), .sfr_wr_i(wr), .sfr_wdata_i(wdata),
    .sfr_rdata_o(rdata), .ovf_o(ovf), .rx_clk_o(rx_clk), .tx_clk_o(tx_clk), .irq_o(irq));

  int n_run = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  int m_cnt, m_cap;
  bit [7:0] m_ctrl;
  bit m_mask;
  bit [2:0] h_trig, h_cpin;

  function automatic int m_read(logic [7:0] a);
    case (a)
      8'hC8: return m_ctrl;
      8'hC9: return {7'b0, m_mask};
      8'hCA: return m_cap & 8'hFF;
      8'hCB: return (m_cap >> 8) & 8'hFF;
      8'hCC: return m_cnt & 8'hFF;
      8'hCD: return (m_cnt >> 8) & 8'hFF;
      default: return 0;
    endcase
  endfunction

  always @(negedge clk) begin : model
    bit [3:0] ht, hc;
    bit baud, incr, ov, tok;
    int nc, ncap;
    bit [7:0] nctrl;
    #3;
    if (!rst_ni) begin
      m_cnt = 0; m_cap = 0; m_ctrl = 0; m_mask = 0; h_trig = 0; h_cpin = 0;
    end else if (!done) begin
      ht = {h_trig, trig_pin};
      hc = {h_cpin, cnt_pin};
      baud = m_ctrl[5] | m_ctrl[4];
      incr = m_ctrl[2] && (m_ctrl[1] ? (hc[3] & ~hc[2]) : tick);
      ov   = incr && m_cnt == 'hFFFF;
      tok  = (ht[3] & ~ht[2]) && m_ctrl[3] && !baud;
      chk("R4 ovf", ovf, ov);
      chk("R10 rx", rx_clk, m_ctrl[5] ? ov : t1_ovf);
      chk("R10 tx", tx_clk, m_ctrl[4] ? ov : t1_ovf);
      chk("R12 irq", irq, m_ctrl[7] | (m_ctrl[6] & ~m_mask));
      chk("R2 rdata", rdata, m_read(addr));
      nc = m_cnt;
      if (incr) nc = ov ? ((baud || !m_ctrl[0]) ? m_cap : 0) : m_cnt + 1;
      if (tok && !m_ctrl[0]) nc = m_cap;
      if (wr && addr == 8'hCC) nc = (nc & 'hFF00) | wdata;
      if (wr && addr == 8'hCD) nc = (nc & 'h00FF) | (int'(wdata) << 8);
      ncap = m_cap;
      if (wr && addr == 8'hCA) ncap = (ncap & 'hFF00) | wdata;
      if (wr && addr == 8'hCB) ncap = (ncap & 'h00FF) | (int'(wdata) << 8);
      if (tok && m_ctrl[0]) ncap = m_cnt;
      nctrl = (wr && addr == 8'hC8) ? wdata : m_ctrl;
      if (ov && !baud) nctrl[7] = 1'b1;
      if (tok) nctrl[6] = 1'b1;
      if (wr && addr == 8'hC9) m_mask = wdata[0];
      m_cnt = nc; m_cap = ncap; m_ctrl = nctrl;
      h_trig = ht[2:0]; h_cpin = hc[2:0];
    end
  end

  task automatic wrr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, int exp, string req);
    @(negedge clk); addr = a; #2;
    chk(req, rdata, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic trig_pulse();
    @(negedge clk); trig_pin = 1'b0; idle(4); trig_pin = 1'b1; idle(4);
  endtask

  task automatic finish_run();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    // R1 reset state
    rd(8'hC8, 0, "R1 ctrl"); rd(8'hC9, 0, "R1 mode"); rd(8'hCA, 0, "R1 cap lo");
    rd(8'hCB, 0, "R1 cap hi"); rd(8'hCC, 0, "R1 cnt lo"); rd(8'hCD, 0, "R1 cnt hi");
    chk("R1 irq", irq, 0);
    // R2 map
    wrr(8'hCA, 8'h34); wrr(8'hCB, 8'h12);
    rd(8'hCA, 8'h34, "R2 cap lo"); rd(8'hCB, 8'h12, "R2 cap hi");
    wrr(8'hC7, 8'hFF); rd(8'hC7, 0, "R2 unmapped"); rd(8'hC8, 0, "R2 unmapped write");
    // R4 R5 reload on overflow
    wrr(8'hCC, 8'hFE); wrr(8'hCD, 8'hFF); wrr(8'hC8, 8'h04);
    ticks(3);
    rd(8'hCC, 8'h35, "R5 reload lo"); rd(8'hCD, 8'h12, "R5 reload hi");
    rd(8'hC8, 8'h84, "R4 flag");
    chk("R12 irq ovf", irq, 1);
    // R11 software clear
    wrr(8'hC8, 8'h04); rd(8'hC8, 8'h04, "R11 clear"); chk("R11 irq", irq, 0);
    // R8 trigger disabled
    trig_pulse();
    rd(8'hCC, 8'h35, "R8 cnt"); rd(8'hC8, 8'h04, "R8 flag");
    // R7 trigger reload
    wrr(8'hC8, 8'h0C);
    trig_pulse();
    rd(8'hCC, 8'h34, "R7 cnt"); rd(8'hC8, 8'h4C, "R7 flag");
    chk("R12 irq trg", irq, 1);
    wrr(8'hC9, 8'h01); rd(8'hC9, 1, "R2 mode"); chk("R12 masked", irq, 0);
    wrr(8'hC9, 8'h00); chk("R12 unmasked", irq, 1);
    // R6 capture
    wrr(8'hC8, 8'h0D); wrr(8'hCD, 8'h00); wrr(8'hCC, 8'hAA);
    trig_pulse();
    rd(8'hCA, 8'hAA, "R6 cap"); rd(8'hC8, 8'h4D, "R6 flag"); rd(8'hCC, 8'hAA, "R6 cnt");
    // R3 pin counting
    wrr(8'hC8, 8'h07);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); cnt_pin = 1'b0; idle(3); cnt_pin = 1'b1; idle(3);
    end
    rd(8'hCC, 8'hAD, "R3 pin count");
    ticks(2); rd(8'hCC, 8'hAD, "R3 tick ignored");
    // R4 R6 capture colliding with overflow
    wrr(8'hC8, 8'h0D);
    @(negedge clk); trig_pin = 1'b0; addr = 8'hCC; wdata = 8'hFF; wr = 1'b1;
    @(negedge clk); addr = 8'hCD;
    @(negedge clk); wr = 1'b0; tick = 1'b1;
    @(negedge clk); tick = 1'b0; trig_pin = 1'b1;
    rd(8'hCA, 8'hFF, "R6 collide cap lo"); rd(8'hCB, 8'hFF, "R6 collide cap hi");
    rd(8'hCC, 0, "R4 wrap lo"); rd(8'hCD, 0, "R4 wrap hi");
    rd(8'hC8, 8'hCD, "R4 R6 flags");
    // R11 set beats clear
    wrr(8'hC8, 8'h0D); wrr(8'hCC, 8'hFF); wrr(8'hCD, 8'hFF);
    @(negedge clk); tick = 1'b1; addr = 8'hC8; wdata = 8'h0D; wr = 1'b1;
    @(negedge clk); tick = 1'b0; wr = 1'b0;
    rd(8'hC8, 8'h8D, "R11 set wins");
    // R13 write beats increment
    @(negedge clk); tick = 1'b1; addr = 8'hCC; wdata = 8'h50; wr = 1'b1;
    @(negedge clk); tick = 1'b0; wr = 1'b0;
    rd(8'hCC, 8'h50, "R13 write wins");
    // R9 R10 baud mode
    wrr(8'hC8, 8'h00);
    wrr(8'hCA, 8'hFD); wrr(8'hCB, 8'hFF); wrr(8'hCC, 8'hFE); wrr(8'hCD, 8'hFF);
    t1_ovf = 1'b1;
    wrr(8'hC8, 8'h2C);
    @(negedge clk); tick = 1'b1; #2;
    chk("R10 rx idle", rx_clk, 0); chk("R10 tx t1", tx_clk, 1);
    @(negedge clk); #2;
    chk("R10 rx ovf", rx_clk, 1);
    @(negedge clk); tick = 1'b0;
    rd(8'hCC, 8'hFD, "R9 reload"); rd(8'hC8, 8'h2C, "R9 no flag");
    trig_pulse();
    rd(8'hCC, 8'hFD, "R9 trig blocked"); rd(8'hC8, 8'h2C, "R9 no trg flag");
    t1_ovf = 1'b0;
    idle(2);
    finish_run();
  end
endmodule